// File: doc/BRIEF.md
# DMA Channel Status and Halt Controller

This block keeps the run/stop and halt state of a single stream-to-memory DMA channel and presents it as a 32-bit status word. Software starts or stops the channel through a run/stop write. The datapath reports progress and trouble through single-cycle pulses: a direct transfer finished, the scatter-gather engine reached the last queued descriptor, the engine has fully wound down, and six error events.

Shutdown is graceful. An error drops run/stop at once, but the channel only reports itself halted after the engine says it has gone quiet. While halted, the write that would start new work is blocked. That write is a tail-pointer update in scatter-gather builds and a length update in direct builds. The meaning of the idle bit depends on the build: in scatter-gather mode it marks that the queue has drained, and in direct mode it marks that the last transfer has finished. The build mode is fixed by a parameter and is visible in the status word.

Top module: `chst_status`

## Requirements
- R1: After reset the status word has halted (bit 0) = 1, idle (bit 1) = 0, all error flags = 0, and run_o = 0.
- R2: Bit 3 reads 1 when SG_EN = 1 and 0 when SG_EN = 0. Bits 2, 7 and 11, and every bit from 12 upward, always read 0.
- R3: An error pulse on err_evt_i[k] sets a flag from the cycle after the pulse. The flag sits at bit 4+k for k = 0..2 (internal, slave, decode) and at bit 5+k for k = 3..5 (scatter-gather internal, slave, decode). Flags are sticky and clear only on reset.
- R4: With SG_EN = 0, err_evt_i[5:3] are ignored. They set no flag and do not stop the channel.
- R5: Any accepted error pulse makes run_o read 0 from the next cycle. The error takes priority over a run write in the same cycle.
- R6: Halted rises only in the cycle after quiesce_i is seen while run_o = 0. A quiesce_i pulse while running has no effect, and a stopped channel that sees no quiesce_i stays un-halted.
- R7: Writing run = 1 while halted, with no error in the same cycle, reads back as run_o = 1 and halted = 0 from the next cycle.
- R8: arm_o repeats arm_wr_i in the same cycle, except when the channel is halted with run_o = 0. In that case arm_o is 0.
- R9: Idle never reads 1 while halted reads 1.
- R10: With SG_EN = 1, a tail_hit_i pulse while running sets idle from the next cycle, and a forwarded arm write clears it. If both arrive in the same cycle, the arm write wins. xfer_done_i has no effect on idle in this mode.
- R11: With SG_EN = 0, idle stays 0 after start until an xfer_done_i pulse while running, and then reads 1. A forwarded arm write clears it. tail_hit_i has no effect on idle in this mode.
- R12: An error that arrives while the channel is halted still sets its flag. The channel stays halted with run_o = 0, even if a run write arrives in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rs_wr_i | input | 1 | Run/stop write strobe |
| rs_wdata_i | input | 1 | Run/stop value written |
| arm_wr_i | input | 1 | Tail-pointer (SG) or length (direct) write strobe |
| tail_hit_i | input | 1 | Engine reached the last queued descriptor |
| xfer_done_i | input | 1 | Direct transfer completed |
| quiesce_i | input | 1 | Engine has completely shut down |
| err_evt_i | input | 6 | Error event pulses, index k as in R3 |
| status_o | output | STATUS_W | Packed status word |
| run_o | output | 1 | Current run/stop state |
| arm_o | output | 1 | Arm write forwarded to the datapath |

## Verification
The bench runs one instance of each build side by side. It sweeps every error index. For each index it checks the flag position, that the error beats a run write in the same cycle, that Halted waits for quiesce, and that a second error arriving while halted is logged without waking the channel. A design that swapped the flag offsets around the reserved bit 7, or let scatter-gather errors through in the direct build, would show a wrong word or a stopped direct channel. Halting on the error itself instead of on quiesce would show Halted one or more cycles early. The bench also targets the idle corner cases: a tail hit and an arm write in the same cycle, a direct-mode idle bit seen before the first transfer, and idle still showing in the cycle Halted rises.

// File: rtl/chst_pkg.sv
`timescale 1ns/1ps
package chst_pkg;
   localparam int unsigned ERR_N    = 6;
   localparam int unsigned ERR_LO_N = 3;
   localparam int unsigned POS_HALT = 0;
   localparam int unsigned POS_IDLE = 1;
   localparam int unsigned POS_MODE = 3;

   typedef enum logic [1:0] {
      CH_HALTED = 2'd0,
      CH_RUN    = 2'd1,
      CH_DRAIN  = 2'd2
   } chan_st_e;

   // error k lands at 4+k for the datapath group, skipping reserved bit 7 for the SG group
   function automatic int unsigned err_pos(int unsigned k);
      return (k < ERR_LO_N) ? (4 + k) : (5 + k);
   endfunction
endpackage

// File: rtl/chst_runctl.sv
`timescale 1ns/1ps
module chst_runctl
   import chst_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic rs_wr_i,
   input  logic rs_wdata_i,
   input  logic err_any_i,
   input  logic quiesce_i,
   output logic run_o,
   output logic halted_o
);
   chan_st_e st_q, st_d;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         CH_HALTED: if (!err_any_i && rs_wr_i && rs_wdata_i) st_d = CH_RUN;
         CH_RUN:    if (err_any_i || (rs_wr_i && !rs_wdata_i)) st_d = CH_DRAIN;
         CH_DRAIN:  if (quiesce_i) st_d = CH_HALTED;
         default:   st_d = CH_HALTED;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= CH_HALTED;
      else        st_q <= st_d;
   end

   assign run_o    = (st_q == CH_RUN);
   assign halted_o = (st_q == CH_HALTED);

   assert_err_drops_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
      err_any_i |=> !run_o);
   assert_halt_needs_quiesce_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(halted_o) |-> ($past(quiesce_i) && !$past(run_o)));
   assert_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (halted_o && rs_wr_i && rs_wdata_i && !err_any_i) |=> (run_o && !halted_o));
endmodule

// File: rtl/chst_errlog.sv
`timescale 1ns/1ps
module chst_errlog
   import chst_pkg::*;
#(
   parameter bit SG_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [ERR_N-1:0] err_evt_i,
   output logic [ERR_N-1:0] flags_o,
   output logic             err_any_o
);
   logic [ERR_N-1:0] mask;
   logic [ERR_N-1:0] err_vld;
   logic [ERR_N-1:0] flags_q;

   generate
      if (SG_EN) begin : g_sg_mask
         assign mask = '1;
      end else begin : g_dr_mask
         assign mask = {{(ERR_N-ERR_LO_N){1'b0}}, {ERR_LO_N{1'b1}}};
      end
   endgenerate

   assign err_vld   = err_evt_i & mask;
   assign err_any_o = |err_vld;

   always_ff @(posedge clk) begin
      if (!rst_n) flags_q <= '0;
      else        flags_q <= flags_q | err_vld;
   end

   assign flags_o = flags_q;

   for (genvar k = 0; k < ERR_N; k++) begin : g_chk
      assert_flag_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
         flags_q[k] |=> flags_q[k]);
      assert_flag_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
         err_vld[k] |=> flags_q[k]);
   end
endmodule

// File: rtl/chst_idle.sv
`timescale 1ns/1ps
module chst_idle #(
   parameter bit SG_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   input  logic halted_i,
   input  logic arm_acc_i,
   input  logic tail_hit_i,
   input  logic xfer_done_i,
   output logic idle_o
);
   logic done_evt;
   logic idle_q;

   generate
      if (SG_EN) begin : g_sg_idle
         assign done_evt = tail_hit_i;
      end else begin : g_dr_idle
         assign done_evt = xfer_done_i;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)                  idle_q <= 1'b0;
      else if (halted_i)           idle_q <= 1'b0;
      else if (arm_acc_i)          idle_q <= 1'b0;
      else if (run_i && done_evt)  idle_q <= 1'b1;
   end

   assign idle_o = idle_q & ~halted_i;

   assert_idle_cleared_R9: assert property (@(posedge clk) disable iff (!rst_n)
      halted_i |=> !idle_q);
   assert_arm_clears_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      arm_acc_i |=> !idle_q);
endmodule

// File: rtl/chst_status.sv
`timescale 1ns/1ps
module chst_status
   import chst_pkg::*;
#(
   parameter bit          SG_EN    = 1'b1,
   parameter int unsigned STATUS_W = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                rs_wr_i,
   input  logic                rs_wdata_i,
   input  logic                arm_wr_i,
   input  logic                tail_hit_i,
   input  logic                xfer_done_i,
   input  logic                quiesce_i,
   input  logic [ERR_N-1:0]    err_evt_i,
   output logic [STATUS_W-1:0] status_o,
   output logic                run_o,
   output logic                arm_o
);
   localparam int unsigned TOP_POS = err_pos(ERR_N - 1);

   initial begin
      assert_width_ok_R2: assert (STATUS_W > TOP_POS)
         else $error("STATUS_W too small for the flag layout");
   end

   logic             run, halted, idle, err_any;
   logic [ERR_N-1:0] flags;

   chst_errlog #(.SG_EN(SG_EN)) u_err (
      .clk(clk), .rst_n(rst_n), .err_evt_i(err_evt_i),
      .flags_o(flags), .err_any_o(err_any)
   );

   chst_runctl u_run (
      .clk(clk), .rst_n(rst_n), .rs_wr_i(rs_wr_i), .rs_wdata_i(rs_wdata_i),
      .err_any_i(err_any), .quiesce_i(quiesce_i),
      .run_o(run), .halted_o(halted)
   );

   assign arm_o = arm_wr_i & ~(halted & ~run);

   chst_idle #(.SG_EN(SG_EN)) u_idle (
      .clk(clk), .rst_n(rst_n), .run_i(run), .halted_i(halted),
      .arm_acc_i(arm_o), .tail_hit_i(tail_hit_i), .xfer_done_i(xfer_done_i),
      .idle_o(idle)
   );

   always_comb begin
      status_o           = '0;
      status_o[POS_HALT] = halted;
      status_o[POS_IDLE] = idle;
      status_o[POS_MODE] = SG_EN;
      for (int k = 0; k < ERR_N; k++) status_o[err_pos(k)] = flags[k];
   end

   assign run_o = run;

   assert_halt_blocks_arm_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (status_o[POS_HALT] && !run_o) |-> !arm_o);
   assert_idle_not_halted_R9: assert property (@(posedge clk) disable iff (!rst_n)
      status_o[POS_HALT] |-> !status_o[POS_IDLE]);
endmodule

// File: tb/chst_status_tb.sv
`timescale 1ns/1ps
module chst_status_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rs_wr = 0, rs_val = 0, arm_wr = 0, tail_hit = 0, xfer_done = 0, quiesce = 0;
   logic [5:0] err = '0;
   logic [31:0] st_sg, st_dr;
   logic run_sg, run_dr, arm_sg, arm_dr;
   int n_chk = 0, n_fail = 0;
   bit done = 0;

   always #5 clk = ~clk;

   chst_status #(.SG_EN(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .rs_wr_i(rs_wr), .rs_wdata_i(rs_val), .arm_wr_i(arm_wr),
      .tail_hit_i(tail_hit), .xfer_done_i(xfer_done), .quiesce_i(quiesce), .err_evt_i(err),
      .status_o(st_sg), .run_o(run_sg), .arm_o(arm_sg));

   chst_status #(.SG_EN(1'b0)) dut_dr_i (
      .clk(clk), .rst_n(rst_n), .rs_wr_i(rs_wr), .rs_wdata_i(rs_val), .arm_wr_i(arm_wr),
      .tail_hit_i(tail_hit), .xfer_done_i(xfer_done), .quiesce_i(quiesce), .err_evt_i(err),
      .status_o(st_dr), .run_o(run_dr), .arm_o(arm_dr));

   function automatic logic [31:0] errw(logic [5:0] f);
      logic [31:0] w = '0;
      for (int k = 0; k < 6; k++) if (f[k]) w[(k < 3) ? 4 + k : 5 + k] = 1'b1;
      return w;
   endfunction

   function automatic logic [31:0] expw(bit h, bit i, bit sg, logic [5:0] f);
      return errw(f) | {28'd0, sg, 1'b0, i, h};
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk); #1;
      rs_wr = 0; rs_val = 0; arm_wr = 0; tail_hit = 0; xfer_done = 0; quiesce = 0; err = '0;
      #1;
   endtask

   task automatic do_reset();
      rst_n = 0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      #1;
   endtask

   task automatic start();
      rs_wr = 1; rs_val = 1;
      tick();
   endtask

   initial begin
      #1000000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      do_reset();
      // R1, R2: reset word in both builds
      chk("R1/R2 sg reset", st_sg, expw(1, 0, 1, 0));
      chk("R1/R2 dr reset", st_dr, expw(1, 0, 0, 0));
      chk("R1 run reset", {30'd0, run_sg, run_dr}, 32'd0);
      // R8: arm write blocked while halted
      arm_wr = 1; #1;
      chk("R8 arm gated halted", {30'd0, arm_sg, arm_dr}, 32'd0);
      tick();
      chk("R8 gated write leaves sg idle", st_sg, expw(1, 0, 1, 0));
      // R7: start
      start();
      chk("R7 run sg/dr", {30'd0, run_sg, run_dr}, 32'd3);
      chk("R7 sg unhalted", st_sg, expw(0, 0, 1, 0));
      chk("R11 dr idle 0 before transfer", st_dr, expw(0, 0, 0, 0));
      arm_wr = 1; #1;
      chk("R8 arm passes running", {30'd0, arm_sg, arm_dr}, 32'd3);
      tick();
      // R10/R11 idle per mode
      tail_hit = 1; tick();
      chk("R10 sg idle on tail", st_sg, expw(0, 1, 1, 0));
      chk("R11 dr ignores tail", st_dr, expw(0, 0, 0, 0));
      xfer_done = 1; tick();
      chk("R11 dr idle on done", st_dr, expw(0, 1, 0, 0));
      chk("R10 sg ignores done", st_sg, expw(0, 1, 1, 0));
      arm_wr = 1; tick();
      chk("R10 arm clears sg idle", st_sg, expw(0, 0, 1, 0));
      chk("R11 arm clears dr idle", st_dr, expw(0, 0, 0, 0));
      arm_wr = 1; tail_hit = 1; xfer_done = 1; tick();
      chk("R10 arm beats tail", st_sg, expw(0, 0, 1, 0));
      chk("R11 arm beats done", st_dr, expw(0, 0, 0, 0));
      // R6: quiesce while running ignored
      quiesce = 1; tick();
      chk("R6 quiesce ignored running", {st_sg[0], st_dr[0], run_sg, run_dr}, 32'h3);
      tail_hit = 1; xfer_done = 1; tick();
      rs_wr = 1; rs_val = 0; tick();
      chk("R6 stopped not halted", {st_sg[0], st_dr[0], run_sg, run_dr}, 32'h0);
      tick(); tick();
      chk("R6 still draining", {st_sg[0], st_dr[0]}, 32'h0);
      quiesce = 1; tick();
      chk("R6/R9 sg halted idle clear", st_sg, expw(1, 0, 1, 0));
      chk("R6/R9 dr halted idle clear", st_dr, expw(1, 0, 0, 0));

      // error sweep over every index
      for (int k = 0; k < 6; k++) begin
         int k2 = (k + 1) % 6;
         logic [5:0] fs, fd;
         bit dr_run;
         do_reset();
         start();
         err[k] = 1; rs_wr = 1; rs_val = 1; tick();
         fs = 6'd1 << k;
         fd = (k < 3) ? fs : 6'd0;
         chk($sformatf("R5 sg run cleared k=%0d", k), {31'd0, run_sg}, 32'd0);
         chk($sformatf("R4/R5 dr run k=%0d", k), {31'd0, run_dr}, (k < 3) ? 32'd0 : 32'd1);
         chk($sformatf("R3/R6 sg word k=%0d", k), st_sg, expw(0, 0, 1, fs));
         chk($sformatf("R4 dr word k=%0d", k), st_dr, expw(0, 0, 0, fd));
         tick(); tick();
         chk($sformatf("R3 sticky k=%0d", k), st_sg, expw(0, 0, 1, fs));
         quiesce = 1; tick();
         chk($sformatf("R6 sg halted k=%0d", k), st_sg, expw(1, 0, 1, fs));
         chk($sformatf("R6 dr state k=%0d", k), st_dr, expw(k < 3, 0, 0, fd));
         // R12: error while halted
         err[k2] = 1; tick();
         fs = fs | (6'd1 << k2);
         dr_run = (k >= 3) && (k2 >= 3);
         if (k2 < 3) fd = fd | (6'd1 << k2);
         chk($sformatf("R12 sg logged k=%0d", k), st_sg, expw(1, 0, 1, fs));
         chk($sformatf("R12 sg run k=%0d", k), {31'd0, run_sg}, 32'd0);
         chk($sformatf("R3/R4 dr flags k=%0d", k), st_dr, expw(k < 3, 0, 0, fd));
         chk($sformatf("R5 dr run k=%0d", k), {31'd0, run_dr}, {31'd0, dr_run});
         err[k] = 1; rs_wr = 1; rs_val = 1; tick();
         chk($sformatf("R12 run write loses k=%0d", k), {st_sg[0], run_sg}, 32'h2);
         // R7: restart keeps sticky flags
         start();
         chk($sformatf("R7/R3 restart k=%0d", k), st_sg, expw(0, 0, 1, fs));
         chk($sformatf("R7 run k=%0d", k), {31'd0, run_sg}, 32'd1);
      end
      do_reset();
      chk("R1/R3 flags cleared by reset", st_sg, expw(1, 0, 1, 0));
      chk("R1 dr after reset", st_dr, expw(1, 0, 0, 0));

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule